// File: doc/BRIEF.md
# Strap-Configured Audio Master Clock Generator

This block produces the serial bit clock and the word (frame) clock of an audio serial port when the port is the clock master. Both clocks are derived synchronously from the incoming master clock. For a short window after reset, the two clock pins are not driven. Their pad levels are treated as configuration straps. After a fixed settling delay the block latches the straps, enables the pin drivers and starts generating the clocks.

The word-clock strap selects single or double speed. The bit-clock strap selects a master-to-word clock ratio of 256x or 384x. A separate pre-divide request doubles the ratio to 512x or 768x in single speed only. The bit clock always runs at 64 times the word-clock rate. The block also emits one-cycle phase strobes that a serializer can use to shift and sample data.

Top module: `amc_master_clkgen`

## Requirements
- R1: While reset is high, and after reset until the straps are latched, both output enables, both clocks and all three strobes are 0.
- R2: The straps are latched on the 16th rising master-clock edge that samples reset low (SETTLE_CYCLES). Both output enables go to 1 at that edge and stay at 1 until the next reset.
- R3: A word-clock strap level of 0 selects single speed. A level of 1 selects double speed, which halves the master cycles per bit-clock period.
- R4: A bit-clock strap level of 0 selects a 256x ratio, which gives 4 master cycles per bit in single speed. A level of 1 selects 384x, which gives 6 master cycles per bit.
- R5: A pre-divide request of 1 doubles the bit period in single speed, to 8 or 12 cycles. In double speed the request has no effect, and the bit period stays at 2 cycles (256x) or 3 cycles (384x).
- R6: With N master cycles per bit, the bit clock starts low in the first cycle after latching. It is low for floor(N/2) cycles and then high for the remaining cycles of each period, repeating.
- R7: The word clock starts low. Within each frame of 64 bit periods it is low for the first 32 and high for the last 32. It changes only in a cycle where the bit clock falls.
- R8: bit_rise_stb is 1 exactly in the cycles where the bit clock has just risen. bit_fall_stb is 1 exactly in the cycles where it has just fallen. frame_stb is 1 exactly in the cycles where the word clock has just fallen.
- R9: Changes on the strap pins or on the pre-divide request after latching have no effect on the clocks until the next reset.
- R10: A reset applied while the clocks run returns the block to the strap phase, and the straps are sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_pad_in | input | 1 | Level seen on the bit-clock pad (ratio strap) |
| wclk_pad_in | input | 1 | Level seen on the word-clock pad (speed strap) |
| prediv_req | input | 1 | Request for divide-by-2 pre-scaling (single speed) |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit-clock pad |
| wclk_out | output | 1 | Generated word clock |
| wclk_oe | output | 1 | Drive enable for the word-clock pad |
| bit_rise_stb | output | 1 | Bit clock has just risen |
| bit_fall_stb | output | 1 | Bit clock has just fallen |
| frame_stb | output | 1 | Word clock has just fallen (new frame) |

## Verification
The generator is run with all eight combinations of speed strap, ratio strap and pre-divide request. This yields bit periods of 2, 3, 4, 6, 8 and 12 cycles. The odd period of 3 separates the low-then-high split from a symmetric one. The double-speed runs with the request set show whether the request leaks into double speed. In two runs the straps and the request are toggled after latching, to show that they are held. Each new case starts by resetting a running generator with different strap levels, which tests resampling after a mid-run reset.

// File: rtl/amc_pkg.sv
package amc_pkg;

    localparam int DIV_W    = 4;
    localparam int RATIO_LO = 256;
    localparam int RATIO_HI = 384;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic dbl_speed;
        logic ratio_hi;
        logic prediv;
    } strap_cfg_t;

    // Master cycles per bit-clock period for a latched configuration.
    function automatic div_t bit_period(strap_cfg_t cfg, int unsigned frame_bits);
        int unsigned n;
        n = (cfg.ratio_hi ? RATIO_HI : RATIO_LO) / frame_bits;
        if (cfg.dbl_speed)
            n = n / 2;
        else if (cfg.prediv)
            n = n * 2;
        return div_t'(n);
    endfunction

endpackage

// File: rtl/amc_strap_latch.sv
module amc_strap_latch
    import amc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_speed,
    input  logic       strap_ratio,
    input  logic       prediv_req,
    output logic       run,
    output strap_cfg_t cfg
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);

    logic [SW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            run        <= 1'b0;
            cfg        <= '0;
        end else if (!run) begin
            if (settle_cnt == SW'(SETTLE_CYCLES - 1)) begin
                run           <= 1'b1;
                cfg.dbl_speed <= strap_speed;
                cfg.ratio_hi  <= strap_ratio;
                cfg.prediv    <= prediv_req;
            end else begin
                settle_cnt <= settle_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/amc_bit_div.sv
module amc_bit_div
    import amc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  div_t period,
    output logic bclk,
    output logic rise_stb,
    output logic fall_stb,
    output logic tick
);
    div_t cnt, cnt_nx, low_len;

    always_comb begin
        low_len = period >> 1;
        tick    = run && (cnt == div_t'(period - 1'b1));
        cnt_nx  = tick ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt      <= '0;
            bclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            bclk     <= (cnt_nx >= low_len);
            rise_stb <= (cnt_nx == low_len);
            fall_stb <= tick;
        end
    end

endmodule

// File: rtl/amc_frame_div.sv
module amc_frame_div #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic wclk,
    output logic frame_stb
);
    localparam int FW   = $clog2(FRAME_BITS);
    localparam int HALF = FRAME_BITS / 2;

    logic [FW-1:0] bit_idx, idx_nx;

    always_comb begin
        idx_nx = (bit_idx == FW'(FRAME_BITS - 1)) ? '0 : bit_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bit_idx   <= '0;
            wclk      <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            frame_stb <= tick && (idx_nx == '0);
            if (tick) begin
                bit_idx <= idx_nx;
                wclk    <= (idx_nx >= FW'(HALF));
            end
        end
    end

endmodule

// File: rtl/amc_master_clkgen.sv
module amc_master_clkgen
    import amc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int FRAME_BITS    = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_pad_in,
    input  logic wclk_pad_in,
    input  logic prediv_req,
    output logic bclk_out,
    output logic bclk_oe,
    output logic wclk_out,
    output logic wclk_oe,
    output logic bit_rise_stb,
    output logic bit_fall_stb,
    output logic frame_stb
);
    strap_cfg_t cfg;
    logic       run;
    logic       tick;
    div_t       period;

    amc_strap_latch #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_strap (
        .clk        (clk),
        .rst        (rst),
        .strap_speed(wclk_pad_in),
        .strap_ratio(bclk_pad_in),
        .prediv_req (prediv_req),
        .run        (run),
        .cfg        (cfg)
    );

    always_comb period = bit_period(cfg, FRAME_BITS);

    amc_bit_div u_bit (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .period  (period),
        .bclk    (bclk_out),
        .rise_stb(bit_rise_stb),
        .fall_stb(bit_fall_stb),
        .tick    (tick)
    );

    amc_frame_div #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tick),
        .wclk     (wclk_out),
        .frame_stb(frame_stb)
    );

    always_comb begin
        bclk_oe = run;
        wclk_oe = run;
    end

endmodule

// File: rtl/amc_master_clkgen_chk.sv
module amc_master_clkgen_chk (
    input logic clk,
    input logic rst,
    input logic bclk_out,
    input logic bclk_oe,
    input logic wclk_out,
    input logic wclk_oe,
    input logic bit_rise_stb,
    input logic bit_fall_stb,
    input logic frame_stb
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !bclk_oe |-> (!bclk_out && !wclk_out && !bit_rise_stb && !bit_fall_stb && !frame_stb));

    p_oe_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        bclk_oe |=> (bclk_oe && wclk_oe));

    p_wclk_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(wclk_out)) |-> $fell(bclk_out));

    p_rise_stb_r8: assert property (@(posedge clk) disable iff (rst)
        bit_rise_stb |-> $rose(bclk_out));

    p_fall_stb_r8: assert property (@(posedge clk) disable iff (rst)
        bit_fall_stb |-> $fell(bclk_out));

    p_frame_stb_r8: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> ($fell(wclk_out) && bit_fall_stb));

    p_stb_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_rise_stb, bit_fall_stb}));

endmodule

bind amc_master_clkgen amc_master_clkgen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bclk_out    (bclk_out),
    .bclk_oe     (bclk_oe),
    .wclk_out    (wclk_out),
    .wclk_oe     (wclk_oe),
    .bit_rise_stb(bit_rise_stb),
    .bit_fall_stb(bit_fall_stb),
    .frame_stb   (frame_stb)
);

// File: tb/sim_amc_master_clkgen.sv
`timescale 1ns/100ps
module sim_amc_master_clkgen;

    localparam int SETTLE = 16;
    localparam int FBITS  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk_pad_in = 1'b0;
    logic wclk_pad_in = 1'b0;
    logic prediv_req  = 1'b0;
    logic bclk_out, bclk_oe, wclk_out, wclk_oe;
    logic bit_rise_stb, bit_fall_stb, frame_stb;

    int total = 0;
    int fails = 0;

    // reference model state
    int  m_cnt  = 0;
    bit  m_run  = 0;
    int  m_k    = 0;
    int  m_n    = 4;
    string ctx  = "R1";

    always #2.5 clk = ~clk;

    amc_master_clkgen #(.SETTLE_CYCLES(SETTLE), .FRAME_BITS(FBITS)) u0 (
        .clk(clk), .rst(rst),
        .bclk_pad_in(bclk_pad_in), .wclk_pad_in(wclk_pad_in), .prediv_req(prediv_req),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .wclk_out(wclk_out), .wclk_oe(wclk_oe),
        .bit_rise_stb(bit_rise_stb), .bit_fall_stb(bit_fall_stb), .frame_stb(frame_stb)
    );

    function automatic int ref_period(bit dbl, bit hi, bit pre);
        int n;
        n = hi ? 6 : 4;
        if (dbl) n = hi ? 3 : 2;
        else if (pre) n = n * 2;
        return n;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] k=%0d actual=%b expected=%b", req, ctx, m_k, act, exp);
        end
    endtask

    task automatic step();
        int c, b;
        bit e_bclk, e_wclk, e_rise, e_fall, e_frame;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_run = 0; m_k = 0;
        end else if (!m_run) begin
            m_cnt++;
            if (m_cnt == SETTLE) begin
                m_run = 1; m_k = 0;
                m_n = ref_period(wclk_pad_in, bclk_pad_in, prediv_req);
            end
        end else begin
            m_k++;
        end
        #1;
        if (!m_run) begin
            e_bclk = 0; e_wclk = 0; e_rise = 0; e_fall = 0; e_frame = 0;
        end else begin
            c = m_k % m_n;
            b = (m_k / m_n) % FBITS;
            e_bclk  = (c >= m_n / 2);
            e_wclk  = (b >= FBITS / 2);
            e_rise  = (c == m_n / 2);
            e_fall  = (c == 0) && (m_k > 0);
            e_frame = e_fall && (b == 0);
        end
        chk(m_run ? "R2 bclk_oe" : "R1 bclk_oe", bclk_oe, m_run);
        chk(m_run ? "R2 wclk_oe" : "R1 wclk_oe", wclk_oe, m_run);
        chk("R6 bclk", bclk_out, e_bclk);
        chk("R7 wclk", wclk_out, e_wclk);
        chk("R8 rise_stb", bit_rise_stb, e_rise);
        chk("R8 fall_stb", bit_fall_stb, e_fall);
        chk("R8 frame_stb", frame_stb, e_frame);
    endtask

    // flip: toggle straps and request once latched (R9)
    task automatic run_case(string tag, bit dbl, bit hi, bit pre, bit flip);
        int n;
        ctx = tag;
        rst = 1'b1;
        wclk_pad_in = dbl; bclk_pad_in = hi; prediv_req = pre;
        repeat (3) step();
        rst = 1'b0;
        repeat (SETTLE) step();
        n = ref_period(dbl, hi, pre);
        if (flip) begin
            wclk_pad_in = !dbl; bclk_pad_in = !hi; prediv_req = !pre;
        end
        repeat (2 * FBITS * n + 5) step();
    endtask

    initial begin
        repeat (2) step();
        run_case("R1 R3 R4 single 256x, R9 straps flipped", 0, 0, 0, 1);
        run_case("R10 R4 single 384x", 0, 1, 0, 0);
        run_case("R10 R3 double 256x", 1, 0, 0, 0);
        run_case("R10 R3 R4 double 384x odd period", 1, 1, 0, 0);
        run_case("R10 R5 single 256x prediv", 0, 0, 1, 0);
        run_case("R10 R5 single 384x prediv, R9 straps flipped", 0, 1, 1, 1);
        run_case("R10 R5 double 256x prediv ignored", 1, 0, 1, 0);
        run_case("R10 R5 double 384x prediv ignored", 1, 1, 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(150000 * 5);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule